// File: doc/BRIEF.md
# Solver Variable Bookkeeping Cell

One instance of this cell exists for each variable of a hardware satisfiability solver. It sits between the decision controller and the clause rows. It watches the three-wire state of its variable: the true rail, the false rail, and the implied flag. From that state it keeps the variable's value, its decision level, and whether the value came from a decision or from an implication. The cell also holds a fixed identification tag, which the controller uses to pick the order of decisions.

The cell reports each new implication with a single-cycle pulse. While the controller analyses a conflict, the cell marks its variable as a literal of the learned clause. It then emits the complemented value together with a write strobe. A backtrack search follows, started by the controller. During that search every marked cell drives its level onto a shared OR bus, one bit per cycle from the most significant bit down. A cell withdraws as soon as it sees that a higher level is on the bus. After as many cycles as the level has bits, the bus holds the largest level among the marked cells, and that level becomes the backtrack level. The controller clears a cell with `clr` when the array is refreshed, and when the cell's level lies above the backtrack level.

Top module: `sat_var_cell`

## Requirements
- R1: After reset, every output except `var_tag` is zero, and `var_tag` equals the TAG parameter.
- R2: The cycle after `imp_in` is first sampled high, `imp_pulse` is high for exactly one cycle. It stays low while `imp_in` remains high.
- R3: A sampled `clr` clears the stored state (`var_set`, `var_lvl`, `var_val`, `var_imp`, the clause mark and the search result). It also re-arms the pulse detector, so an `imp_in` that is still high produces a new pulse one cycle after `clr` drops.
- R4: The state code is {lit_p, lit_n, imp_in}. While the cell is empty, a code of 100 or 010 (decision) or 101 or 011 (implication) stores `cur_lvl`, the value `lit_p` and the implied flag `imp_in`. Once stored, these fields ignore later changes of `cur_lvl` until `clr`.
- R5: The codes 000 (free), 111 (conflict) and 110 (clause literal) store nothing in an empty cell.
- R6: When `mark_req` is sampled together with code 110, then in the next cycle `learn_wr` is 1 and `learn_lit` is the inverse of the stored value. In every other case both are 0 in the next cycle.
- R7: When `bt_go` is sampled, `bt_valid` rises exactly LVL_W cycles later. At that point the OR of all cells' `bt_drive` equals the largest `var_lvl` among the cells marked under R6.
- R8: A cell that was not marked under R6 before `bt_go` drives zero on every bit of `bt_drive`.
- R9: After `bt_valid` rises, a marked cell drives its full level if that level equals the largest level, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Controller clear of the stored state and the pulse detector |
| lit_p | input | 1 | True rail of the variable |
| lit_n | input | 1 | False rail of the variable |
| imp_in | input | 1 | Implied flag of the variable |
| cur_lvl | input | LVL_W | Current decision level |
| mark_req | input | 1 | Conflict analysis: capture the clause literal |
| bt_go | input | 1 | Start of the backtrack level search |
| bt_bus | input | LVL_W | Resolved OR of all cells' bt_drive |
| imp_pulse | output | 1 | One-cycle new implication pulse |
| learn_wr | output | 1 | Write strobe for the learned clause |
| learn_lit | output | 1 | Complemented value for the learned clause |
| bt_drive | output | LVL_W | This cell's contribution to the backtrack bus |
| bt_valid | output | 1 | Backtrack search finished |
| var_set | output | 1 | Variable holds a decision or implication |
| var_val | output | 1 | Stored value |
| var_imp | output | 1 | Stored value came from an implication |
| var_lvl | output | LVL_W | Stored decision level |
| var_tag | output | TAG_W | Identification tag |

## Verification
The assertions assume that `bt_bus` is the OR of the cell's own `bt_drive` with the drives of its peers. They also assume that the stored levels and clause marks stay steady while a search runs. The bench meets both assumptions by building the bus from three cell instances, of which one is under comparison, and by changing no state code or mark between `bt_go` and the end of the search. Each scenario begins with `clr`, so the cells are empty when levels are recorded again.

// File: rtl/sat_var_cell.sv
module sat_var_cell #(
  parameter int LVL_W = 4,
  parameter int TAG_W = 8,
  parameter logic [TAG_W-1:0] TAG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             lit_p,
  input  logic             lit_n,
  input  logic             imp_in,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             mark_req,
  input  logic             bt_go,
  input  logic [LVL_W-1:0] bt_bus,
  output logic             imp_pulse,
  output logic             learn_wr,
  output logic             learn_lit,
  output logic [LVL_W-1:0] bt_drive,
  output logic             bt_valid,
  output logic             var_set,
  output logic             var_val,
  output logic             var_imp,
  output logic [LVL_W-1:0] var_lvl,
  output logic [TAG_W-1:0] var_tag
);
  localparam int IW = (LVL_W > 1) ? $clog2(LVL_W) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(LVL_W - 1);

  logic [2:0] code;
  logic rec_code, cc_hit;
  logic fa, fb;
  logic in_cc, alive, busy;
  logic [IW-1:0] idx;
  logic [LVL_W-1:0] mask;

  assign code     = {lit_p, lit_n, imp_in};
  assign rec_code = lit_p ^ lit_n;
  assign cc_hit   = mark_req && (code == 3'b110);
  assign imp_pulse = fa & ~fb;
  assign var_tag  = TAG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa <= 1'b0;
      fb <= 1'b0;
    end else if (clr) begin
      fa <= 1'b0;
      fb <= 1'b0;
    end else begin
      fa <= fa | imp_in;
      fb <= fa;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      var_set <= 1'b0;
      var_val <= 1'b0;
      var_imp <= 1'b0;
      var_lvl <= '0;
    end else if (clr) begin
      var_set <= 1'b0;
      var_val <= 1'b0;
      var_imp <= 1'b0;
      var_lvl <= '0;
    end else if (!var_set && rec_code) begin
      var_set <= 1'b1;
      var_val <= lit_p;
      var_imp <= imp_in;
      var_lvl <= cur_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      learn_wr  <= 1'b0;
      learn_lit <= 1'b0;
      in_cc     <= 1'b0;
    end else begin
      learn_wr  <= cc_hit;
      learn_lit <= cc_hit ? ~var_val : 1'b0;
      if (clr)
        in_cc <= 1'b0;
      else if (cc_hit)
        in_cc <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bt_valid <= 1'b0;
      alive    <= 1'b0;
      idx      <= '0;
    end else if (clr) begin
      busy     <= 1'b0;
      bt_valid <= 1'b0;
      alive    <= 1'b0;
      idx      <= '0;
    end else if (bt_go) begin
      busy     <= 1'b1;
      bt_valid <= 1'b0;
      alive    <= in_cc;
      idx      <= TOP_IDX;
    end else if (busy) begin
      if (!var_lvl[idx] && bt_bus[idx])
        alive <= 1'b0;
      if (idx == '0) begin
        busy     <= 1'b0;
        bt_valid <= 1'b1;
      end else begin
        idx <= idx - 1'b1;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < LVL_W; b++)
      mask[b] = bt_valid | (busy && (b >= int'(idx)));
  end

  assign bt_drive = alive ? (var_lvl & mask) : '0;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    imp_pulse |=> !imp_pulse); // R2
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    imp_pulse |-> $past(imp_in) && !$past(clr)); // R2
  AST_LVL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    var_set && $past(var_set) && !$past(clr) |-> $stable(var_lvl) && $stable(var_val)); // R4
  AST_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    !var_set && !rec_code |=> !var_set); // R5
  AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cc_hit |=> learn_wr); // R6
  AST_WR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    learn_wr |-> $past(mark_req)); // R6
  AST_DRIVE_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid |-> (bt_drive & ~bt_bus) == '0); // R7
  AST_UNMARKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cc && !$past(in_cc) |-> bt_drive == '0); // R8
endmodule

// File: tb/sat_var_cell_test.sv
module sat_var_cell_test;
  localparam int CLK_P = 10;
  localparam int LW = 4;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0, clr = 0, mark = 0, go = 0;
  logic [LW-1:0] cur = '0;
  logic lp [3], ln [3], vi [3];
  logic [LW-1:0] drv [3], lvl_o [3];
  logic pul [3], wr_o [3], wl_o [3], val_ok [3], set_o [3], vv_o [3], vimp_o [3];
  logic [TW-1:0] tag_o [3];
  logic [LW-1:0] bus;
  int vectors = 0, bad = 0;

  assign bus = drv[0] | drv[1] | drv[2];
  always #(CLK_P/2) clk = ~clk;

  sat_var_cell #(.LVL_W(LW), .TAG_W(TW), .TAG(8'h21)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lit_p(lp[0]), .lit_n(ln[0]), .imp_in(vi[0]),
    .cur_lvl(cur), .mark_req(mark), .bt_go(go), .bt_bus(bus),
    .imp_pulse(pul[0]), .learn_wr(wr_o[0]), .learn_lit(wl_o[0]), .bt_drive(drv[0]),
    .bt_valid(val_ok[0]), .var_set(set_o[0]), .var_val(vv_o[0]), .var_imp(vimp_o[0]),
    .var_lvl(lvl_o[0]), .var_tag(tag_o[0]));
  sat_var_cell #(.LVL_W(LW), .TAG_W(TW), .TAG(8'h22)) peer1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lit_p(lp[1]), .lit_n(ln[1]), .imp_in(vi[1]),
    .cur_lvl(cur), .mark_req(mark), .bt_go(go), .bt_bus(bus),
    .imp_pulse(pul[1]), .learn_wr(wr_o[1]), .learn_lit(wl_o[1]), .bt_drive(drv[1]),
    .bt_valid(val_ok[1]), .var_set(set_o[1]), .var_val(vv_o[1]), .var_imp(vimp_o[1]),
    .var_lvl(lvl_o[1]), .var_tag(tag_o[1]));
  sat_var_cell #(.LVL_W(LW), .TAG_W(TW), .TAG(8'h23)) peer2 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lit_p(lp[2]), .lit_n(ln[2]), .imp_in(vi[2]),
    .cur_lvl(cur), .mark_req(mark), .bt_go(go), .bt_bus(bus),
    .imp_pulse(pul[2]), .learn_wr(wr_o[2]), .learn_lit(wl_o[2]), .bt_drive(drv[2]),
    .bt_valid(val_ok[2]), .var_set(set_o[2]), .var_val(vv_o[2]), .var_imp(vimp_o[2]),
    .var_lvl(lvl_o[2]), .var_tag(tag_o[2]));

  // behavioural reference for all three cells
  bit m_a [3], m_b [3], m_held [3], m_val [3], m_imp [3], m_cc [3], m_wr [3], m_wl [3], m_ccg [3];
  int m_lvl [3];
  bit m_busy = 0, m_valid = 0;
  int m_idx = 0;

  initial begin
    for (int j = 0; j < 3; j++) begin
      lp[j] = 0; ln[j] = 0; vi[j] = 0;
      m_a[j] = 0; m_b[j] = 0; m_held[j] = 0; m_val[j] = 0; m_imp[j] = 0;
      m_cc[j] = 0; m_wr[j] = 0; m_wl[j] = 0; m_ccg[j] = 0; m_lvl[j] = 0;
    end
  end

  function automatic int max_marked();
    int mx = 0;
    for (int k = 0; k < 3; k++)
      if (m_ccg[k] && m_lvl[k] > mx) mx = m_lvl[k];
    return mx;
  endfunction

  function automatic int exp_drive(int j);
    int mx, msk;
    if (!(m_busy || m_valid) || !m_ccg[j]) return 0;
    mx = max_marked();
    if (m_valid) return (m_lvl[j] == mx) ? m_lvl[j] : 0;
    msk = ((1 << LW) - 1) & ~((1 << m_idx) - 1);
    if ((m_lvl[j] >> (m_idx + 1)) == (mx >> (m_idx + 1))) return m_lvl[j] & msk;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_idx = 0;
      for (int j = 0; j < 3; j++) begin
        m_a[j] = 0; m_b[j] = 0; m_held[j] = 0; m_val[j] = 0; m_imp[j] = 0;
        m_cc[j] = 0; m_wr[j] = 0; m_wl[j] = 0; m_ccg[j] = 0; m_lvl[j] = 0;
      end
    end else begin
      if (clr) begin
        m_busy = 0; m_valid = 0;
        for (int j = 0; j < 3; j++) m_ccg[j] = 0;
      end else if (go) begin
        m_busy = 1; m_valid = 0; m_idx = LW - 1;
        for (int j = 0; j < 3; j++) m_ccg[j] = m_cc[j];
      end else if (m_busy) begin
        if (m_idx == 0) begin m_busy = 0; m_valid = 1; end
        else m_idx = m_idx - 1;
      end
      for (int j = 0; j < 3; j++) begin
        bit hit;
        hit = mark && lp[j] && ln[j] && !vi[j];
        m_wl[j] = hit ? !m_val[j] : 1'b0;
        m_wr[j] = hit;
        m_b[j] = clr ? 1'b0 : m_a[j];
        m_a[j] = clr ? 1'b0 : (m_a[j] | vi[j]);
        if (clr) begin
          m_held[j] = 0; m_val[j] = 0; m_imp[j] = 0; m_lvl[j] = 0; m_cc[j] = 0;
        end else begin
          if (!m_held[j] && (lp[j] ^ ln[j])) begin
            m_held[j] = 1; m_val[j] = lp[j]; m_imp[j] = vi[j]; m_lvl[j] = int'(cur);
          end
          if (hit) m_cc[j] = 1;
        end
      end
    end
  end

  task automatic fld(string req, string nm, int act, int expv, inout bit ok);
    if (act != expv) begin
      $display("FAIL %s %s: actual %0d expected %0d", req, nm, act, expv);
      ok = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit ok = 1;
      fld("R2", "imp_pulse", int'(pul[0]), int'(m_a[0] & !m_b[0]), ok);
      fld("R6", "learn_wr", int'(wr_o[0]), int'(m_wr[0]), ok);
      fld("R6", "learn_lit", int'(wl_o[0]), int'(m_wl[0]), ok);
      fld("R7", "bt_drive", int'(drv[0]), exp_drive(0), ok);
      fld("R7", "bt_valid", int'(val_ok[0]), int'(m_valid), ok);
      fld("R4", "var_set", int'(set_o[0]), int'(m_held[0]), ok);
      fld("R4", "var_val", int'(vv_o[0]), int'(m_val[0]), ok);
      fld("R4", "var_imp", int'(vimp_o[0]), int'(m_imp[0]), ok);
      fld("R4", "var_lvl", int'(lvl_o[0]), m_lvl[0], ok);
      vectors++;
      if (!ok) bad++;
    end
  end

  task automatic chk(string req, int act, int expv);
    vectors++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setc(int j, logic [2:0] c);
    lp[j] = c[2]; ln[j] = c[1]; vi[j] = c[0];
  endtask

  task automatic clear_all();
    for (int j = 0; j < 3; j++) setc(j, 3'b000);
    mark = 0; go = 0; clr = 1;
    tick();
    clr = 0;
  endtask

  task automatic record(int j, logic [2:0] c, int l);
    setc(j, c); cur = LW'(l);
    tick();
  endtask

  task automatic mark_all(bit m0, bit m1, bit m2);
    if (m0) setc(0, 3'b110);
    if (m1) setc(1, 3'b110);
    if (m2) setc(2, 3'b110);
    mark = 1;
    tick();
    mark = 0;
  endtask

  task automatic search(string req, int exp_bus, int exp_own);
    go = 1;
    tick();
    go = 0;
    repeat (LW - 1) tick();
    chk({req, " valid not yet"}, int'(val_ok[0]), 0);
    tick();
    chk({req, " valid after LVL_W cycles"}, int'(val_ok[0]), 1);
    chk({req, " bus max"}, int'(bus), exp_bus);
    chk({req, " own drive"}, int'(drv[0]), exp_own);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 var_set", int'(set_o[0]), 0);
    chk("R1 bt_drive", int'(drv[0]), 0);
    chk("R1 var_tag", int'(tag_o[0]), 8'h21);
    rst_n = 1;
    tick();
    chk("R1 imp_pulse", int'(pul[0]), 0);
    chk("R1 learn_wr", int'(wr_o[0]), 0);

    // R4 decision at level 3, later level changes ignored
    record(0, 3'b100, 3);
    chk("R4 level stored", int'(lvl_o[0]), 3);
    chk("R4 value stored", int'(vv_o[0]), 1);
    cur = 5;
    tick();
    chk("R4 level held", int'(lvl_o[0]), 3);
    chk("R4 decision not implied", int'(vimp_o[0]), 0);
    clear_all();
    chk("R3 clr empties", int'(set_o[0]), 0);

    // R2 implication pulse
    record(0, 3'b011, 6);
    chk("R2 pulse", int'(pul[0]), 1);
    chk("R4 implied flag", int'(vimp_o[0]), 1);
    tick();
    chk("R2 pulse single", int'(pul[0]), 0);
    tick();
    chk("R2 no repeat", int'(pul[0]), 0);

    // R3 clr re-arms while imp_in stays high
    clr = 1;
    tick();
    clr = 0;
    chk("R3 cleared", int'(set_o[0]), 0);
    chk("R3 no pulse during clr", int'(pul[0]), 0);
    tick();
    chk("R3 pulse again", int'(pul[0]), 1);
    clear_all();

    // R5 codes that record nothing
    setc(0, 3'b111); tick(); chk("R5 code 111", int'(set_o[0]), 0);
    setc(0, 3'b110); tick(); chk("R5 code 110", int'(set_o[0]), 0);
    setc(0, 3'b000); tick(); chk("R5 code 000", int'(set_o[0]), 0);
    clear_all();

    // R6 learned literal, then search with lower peer (R9) and unmarked peer (R8)
    record(0, 3'b100, 5);
    record(1, 3'b010, 3);
    record(2, 3'b101, 2);
    mark_all(1, 1, 0);
    chk("R6 write strobe", int'(wr_o[0]), 1);
    chk("R6 complement", int'(wl_o[0]), 0);
    chk("R6 peer complement", int'(wl_o[1]), 1);
    tick();
    chk("R6 no mark no write", int'(wr_o[0]), 0);
    search("R7", 5, 5);
    chk("R9 lower peer quiet", int'(drv[1]), 0);
    chk("R8 unmarked peer quiet", int'(drv[2]), 0);
    clear_all();

    // R9 own level below a tied pair
    record(0, 3'b100, 2);
    record(1, 3'b010, 9);
    record(2, 3'b101, 9);
    mark_all(1, 1, 1);
    search("R9", 9, 0);
    clear_all();

    // R8 nothing marked
    record(0, 3'b100, 7);
    tick();
    search("R8", 0, 0);
    clear_all();

    // R7 extremes: top level and zero level
    record(0, 3'b010, 15);
    record(1, 3'b100, 0);
    mark_all(1, 1, 0);
    search("R7 top", 15, 15);
    clear_all();
    record(0, 3'b011, 0);
    mark_all(1, 0, 0);
    search("R7 zero", 0, 0);
    clear_all();
    tick();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule